// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder with Bubble Correction

This block sits behind the comparator bank of a flash converter. Each comparator compares the input against one rung of a reference ladder. The bank therefore delivers a unary word: ideally a run of ones from the lowest tap up to the input level, with zeros above it. The block turns that word into an n-bit binary result.

Noise, process variation or a harsh environment can make a single comparator trip when it should not. These stray highs are called bubbles. Before encoding, a neighbour-voting stage clears any bit that is high while both of its neighbours are low. The encoder then reports the position of the highest remaining set bit. A one-cycle flag marks every sample in which at least one bit was cleared.

The comparator word is registered on entry, and the code and flag are registered on exit. One sample is accepted on every clock cycle. The resolution `RES_BITS` runs from 2 to 8, which gives from 3 to 255 comparator inputs.

Top module: `therm_bubble_enc`

## Requirements
- R1: While `rst_ni` is low, `code_o` and `fix_flag_o` are 0. Reset is asynchronous and takes effect without a clock edge.
- R2: A word present at rising edge k appears on `code_o`/`fix_flag_o` after rising edge k+1. A new word is accepted at every edge, so back-to-back samples each get their own result.
- R3: A clean thermometer word (bits 0..k-1 high, the rest low) gives `code_o` = k and `fix_flag_o` = 0.
- R4: An all-zero word gives 0. An all-ones word gives 2^RES_BITS-1. Neither raises the flag.
- R5: An interior bit i that is high while bits i-1 and i+1 are both low is cleared before encoding.
- R6: For the top bit (index 2^RES_BITS-2), the missing upper neighbour counts as 0. The top bit is therefore cleared whenever the bit below it is low.
- R7: For bit 0, the missing lower neighbour counts as 1. Bit 0 is therefore never cleared, and a word with only bit 0 high gives 1.
- R8: After correction, `code_o` is the index of the highest set bit plus one, even when gaps remain below it. For example, with RES_BITS=3, word 7'b0110000 gives 6.
- R9: `fix_flag_o` is high for exactly the sample in which at least one bit was cleared, and low for every other sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| therm_i | input | 2^RES_BITS-1 | Comparator word; bit 0 belongs to the lowest reference tap |
| code_o | output | RES_BITS | Registered binary result |
| fix_flag_o | output | 1 | High when a bubble was cleared in the sample shown on `code_o` |

## Verification
The assertions do not expect the comparator word to be a clean thermometer code. They do take for granted that `therm_i` is a defined value at every rising edge once reset is released, and that the last two words sampled can be paired with the current output. The checker keeps its own two-deep history of inputs and a cycles-since-reset counter for this pairing. The stimulus drives the input only on falling edges, and the code sweeps cover every word of the 3-bit and 2-bit configurations back to back. This keeps every sampled value defined and lets every output be paired with a known input.

// File: rtl/therm_pkg.sv
package therm_pkg;
  localparam int MIN_RES = 2;
  localparam int MAX_RES = 8;

  function automatic int cmp_count(input int res);
    return (1 << res) - 1;
  endfunction
endpackage

// File: rtl/therm_bubble_fix.sv
// Neighbour vote: a high bit survives if either neighbour is high.
module therm_bubble_fix #(
  parameter int N = 7
) (
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] fixed_o,
  output logic         any_cleared_o
);
  logic [N-1:0] keep;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic lo_nb, hi_nb;
    if (i == 0) begin : g_bot
      assign lo_nb = 1'b1;          // below the ladder counts as tripped
    end else begin : g_lo
      assign lo_nb = raw_i[i-1];
    end
    if (i == N-1) begin : g_top
      assign hi_nb = 1'b0;          // above the ladder counts as untripped
    end else begin : g_hi
      assign hi_nb = raw_i[i+1];
    end
    assign keep[i] = lo_nb | hi_nb;
  end

  assign fixed_o       = raw_i & keep;
  assign any_cleared_o = |(raw_i & ~keep);
endmodule

// File: rtl/therm_top_encode.sv
// Highest-set-bit encoder: suffix OR chain isolates the top edge, then OR-encode.
module therm_top_encode #(
  parameter int RES_BITS = 3,
  localparam int N = (1 << RES_BITS) - 1
) (
  input  logic [N-1:0]        therm_i,
  output logic [RES_BITS-1:0] code_o
);
  logic [N-1:0] above;
  logic [N-1:0] edge_oh;

  assign above[N-1] = 1'b0;
  for (genvar i = N-2; i >= 0; i--) begin : g_sfx
    assign above[i] = above[i+1] | therm_i[i+1];
  end
  assign edge_oh = therm_i & ~above;

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (edge_oh[i]) code_o = code_o | RES_BITS'(i + 1);
    end
  end
endmodule

// File: rtl/therm_bubble_enc.sv
module therm_bubble_enc
  import therm_pkg::*;
#(
  parameter int RES_BITS = 3,
  localparam int NUM_CMP = (1 << RES_BITS) - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CMP-1:0]  therm_i,
  output logic [RES_BITS-1:0] code_o,
  output logic                fix_flag_o
);
  if (RES_BITS < MIN_RES || RES_BITS > MAX_RES) begin : g_bad_res
    $error("RES_BITS out of range");
  end

  logic [NUM_CMP-1:0]  therm_q;
  logic [NUM_CMP-1:0]  fixed;
  logic                cleared;
  logic [RES_BITS-1:0] code_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) therm_q <= '0;
    else         therm_q <= therm_i;
  end

  therm_bubble_fix #(.N(NUM_CMP)) u_fix (
    .raw_i         (therm_q),
    .fixed_o       (fixed),
    .any_cleared_o (cleared)
  );

  therm_top_encode #(.RES_BITS(RES_BITS)) u_enc (
    .therm_i (fixed),
    .code_o  (code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o     <= '0;
      fix_flag_o <= 1'b0;
    end else begin
      code_o     <= code_d;
      fix_flag_o <= cleared;
    end
  end
endmodule

// File: rtl/therm_bubble_enc_chk.sv
module therm_bubble_enc_chk #(
  parameter int RES_BITS = 3,
  localparam int N = (1 << RES_BITS) - 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N-1:0]        therm_i,
  input logic [RES_BITS-1:0] code_o,
  input logic                fix_flag_o
);
  logic [1:0]   since_rst;
  logic [N-1:0] h1, h2;
  logic [N-1:0] h2_inc;
  logic         rdy, h2_is_therm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= '0;
      h1 <= '0;
      h2 <= '0;
    end else begin
      if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
      h1 <= therm_i;
      h2 <= h1;
    end
  end

  assign rdy         = (since_rst == 2'd2);
  assign h2_inc      = h2 + 1'b1;
  assign h2_is_therm = ((h2 & h2_inc) == '0);

  // R3
  thermo_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy && h2_is_therm |-> code_o == RES_BITS'($countones(h2)) && !fix_flag_o);

  // R4
  all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy && (&h2) |-> (&code_o));

  // R9
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy && fix_flag_o |-> !h2_is_therm);

  // R6
  top_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy && h2[N-1] && !h2[N-2] |-> !(&code_o) && fix_flag_o);

  // R7
  bottom_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy && h2[0] |-> code_o != '0);
endmodule

bind therm_bubble_enc therm_bubble_enc_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .therm_i    (therm_i),
  .code_o     (code_o),
  .fix_flag_o (fix_flag_o)
);

// File: tb/sim_therm_bubble_enc.sv
`timescale 1ns/1ps
module sim_therm_bubble_enc;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic [6:0] therm0 = '0;
  logic [2:0] therm1 = '0;
  logic [2:0] code0;
  logic [1:0] code1;
  logic       flag0, flag1;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  therm_bubble_enc #(.RES_BITS(3)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .therm_i(therm0), .code_o(code0), .fix_flag_o(flag0));
  therm_bubble_enc #(.RES_BITS(2)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .therm_i(therm1), .code_o(code1), .fix_flag_o(flag1));

  // Expected result computed from the requirements
  function automatic void model(input int n, input int p, output int code, output int flag);
    int fx;
    fx = 0; flag = 0; code = 0;
    for (int i = 0; i < n; i++) begin
      int lo, hi;
      lo = (i == 0) ? 1 : ((p >> (i-1)) & 1);
      hi = (i == n-1) ? 0 : ((p >> (i+1)) & 1);
      if ((p >> i) & 1) begin
        if (lo | hi) fx |= (1 << i);
        else flag = 1;
      end
    end
    for (int i = 0; i < n; i++) if ((fx >> i) & 1) code = i + 1;
  endfunction

  function automatic string tag_of(input int n, input int p);
    if (p == 0 || p == (1 << n) - 1) return "R4";
    if ((p & (p + 1)) == 0) return "R3";
    return "R8";
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic one_shot(input string tag, input int p);
    int ec, ef;
    @(negedge clk); therm0 = p[6:0];
    @(negedge clk); therm0 = '0;
    @(negedge clk);
    model(7, p, ec, ef);
    chk({tag, " code"}, code0, ec);
    chk({tag, " flag"}, flag0, ef);
  endtask

  initial begin
    #5 rst_ni = 1'b0;
    therm0 = 7'h7f; therm1 = 3'h7;
    repeat (3) @(negedge clk);
    chk("R1 code0 in reset", code0, 0);
    chk("R1 flag0 in reset", flag0, 0);
    chk("R1 code1 in reset", code1, 0);
    rst_ni = 1'b1; therm0 = '0; therm1 = '0;

    // Back-to-back sweep of all 128 words, 3-bit resolution
    for (int j = 0; j < 130; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        int ec, ef;
        model(7, j-2, ec, ef);
        chk({"R2 ", tag_of(7, j-2), " code0"}, code0, ec);
        chk("R2 R9 flag0", flag0, ef);
      end
      therm0 = (j < 128) ? 7'(j) : 7'h00;
    end

    // Back-to-back sweep of all 8 words, 2-bit resolution
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        int ec, ef;
        model(3, j-2, ec, ef);
        chk({"R2 ", tag_of(3, j-2), " code1"}, code1, ec);
        chk("R2 R9 flag1", flag1, ef);
      end
      therm1 = (j < 8) ? 3'(j) : 3'h0;
    end

    one_shot("R5 interior bubble", 7'b0000100);
    one_shot("R5 two bubbles",     7'b0010101);
    one_shot("R6 top bubble",      7'b1000011);
    one_shot("R7 bottom alone",    7'b0000001);
    one_shot("R8 gap below",       7'b0110000);
    one_shot("R3 clean five",      7'b0011111);

    // R9: flag clears on the next clean sample
    @(negedge clk); therm0 = 7'b0000100;
    @(negedge clk); therm0 = 7'b0000111;
    @(negedge clk); chk("R9 flag set", flag0, 1);
    @(negedge clk); chk("R9 flag one cycle", flag0, 0);
    chk("R9 next code", code0, 3);

    // R1: asynchronous reset mid-run
    therm0 = 7'h7f;
    repeat (3) @(negedge clk);
    chk("R4 ones before reset", code0, 7);
    #3 rst_ni = 1'b0;
    #1 chk("R1 async clear code", code0, 0);
    chk("R1 async clear flag", flag0, 0);
    @(negedge clk); rst_ni = 1'b1;
    finish_run();
  end

  initial begin
    #(20 * 5000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule